// File: doc/BRIEF.md
# LCD Command Sequencer for Power-Up and Contrast

This block brings a small monochrome graphic LCD controller out of reset and keeps its contrast setting current. It works through an 8-bit byte link that a separate serializer shifts out. A start strobe makes it drive the panel reset low for a set number of cycles and then wait a settling time. After that it sends the power-up command list. The list ends with the contrast setting that is currently stored.

The controller has two instruction banks. The bias, first-line and contrast commands sit in the extended bank, so the sequencer brackets them with the byte that enters the extended set and the byte that returns to the standard set.

A contrast request stores a 7-bit value and sends it inside such a bracket. A request that arrives while a sequence is running is held and served after that sequence. Several held requests merge, and the last value wins.

The data/command line stays low for every command byte. It returns high when the block is idle, so the pixel path can own the link. A one-cycle done pulse marks the end of each sequence.

Top module: `lcd_cmd_seq`

## Requirements
- R1: After reset, `lcd_rst_n_o` is 1, `byte_valid_o` is 0, `done_o` is 0 and `lcd_dc_o` is 1.
- R2: A start strobe seen while idle drives `lcd_rst_n_o` low for exactly RST_LOW_CYC cycles (default 4). It then holds it high for RST_WAIT_CYC cycles before the first byte is offered. No byte is offered while `lcd_rst_n_o` is low.
- R3: The power-up list is sent in this order: 0x21, 0x10 OR the bias sampled with the start strobe, 0x05, 0x40, 0x20, 0x0C. The default first line is 64, which gives upper bit 1 in 0x04|b and lower six bits 0 in 0x40|b. The list then continues with 0x21, 0x80 OR the stored contrast, 0x20.
- R4: After reset the stored contrast is 0x28.
- R5: A contrast request seen while idle stores `con_val_i` and sends 0x21, then 0x80 OR the value, then 0x20.
- R6: While `byte_valid_o` is high and `byte_ready_i` is low, `byte_o` and `byte_valid_o` hold. A byte counts as sent on a cycle with both high. The next byte may be offered in the following cycle.
- R7: `lcd_dc_o` is low for the whole of every sequence and whenever a byte is offered.
- R8: Contrast requests made while a sequence runs are held. After that sequence one contrast bracket is sent, carrying the value of the last request.
- R9: A start strobe seen while a sequence runs has no effect. No reset pulse and no extra bytes follow from it.
- R10: `done_o` is high for exactly one cycle after the last byte of each sequence is sent. It is never high while a byte is offered.
- R11: When start and a contrast request arrive together while idle, the power-up list runs first, with the contrast stored before that cycle. A bracket with the new value follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin the power-up sequence (ignored while busy) |
| bias_i | input | 3 | Bias level placed in the bias command |
| con_req_i | input | 1 | Contrast update request |
| con_val_i | input | 7 | Contrast value for the request |
| byte_o | output | 8 | Command byte offered to the serializer |
| byte_valid_o | output | 1 | `byte_o` is valid |
| byte_ready_i | input | 1 | Serializer accepts the offered byte |
| lcd_rst_n_o | output | 1 | Panel reset, active low |
| lcd_dc_o | output | 1 | Data/command select, low for commands |
| done_o | output | 1 | One-cycle pulse when a sequence ends |

## Verification
The following properties are checked on every cycle:
- the byte hold under back-pressure;
- the low command line while a byte is offered;
- the absence of bytes during panel reset;
- the exact width of the reset pulse;
- the single-cycle done pulse.

Other behaviour shows only in whole scenarios: the byte order of each list, the use of the sampled bias and stored contrast, the merging of held requests, the ignored start during a running sequence, and start-and-request arbitration. The bench compares the complete byte stream of each scenario with lists it builds from the requirements.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_RESET,
        SQ_SEND
    } sq_state_e;

    typedef enum logic [1:0] {
        TM_IDLE,
        TM_LOW,
        TM_WAIT
    } tm_phase_e;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
    } cmd_slot_t;

    localparam logic [7:0] OP_BANK_EXT  = 8'h21;
    localparam logic [7:0] OP_BANK_STD  = 8'h20;
    localparam logic [7:0] OP_BIAS      = 8'h10;
    localparam logic [7:0] OP_LINE_HI   = 8'h04;
    localparam logic [7:0] OP_LINE_LO   = 8'h40;
    localparam logic [7:0] OP_DISP_NORM = 8'h0C;
    localparam logic [7:0] OP_CONTRAST  = 8'h80;

    localparam int unsigned IDX_W    = 4;
    localparam logic [IDX_W-1:0] IDX_CON  = 4'd6;
    localparam logic [IDX_W-1:0] IDX_LAST = 4'd8;

    function automatic logic [7:0] seq_byte(
        input logic [IDX_W-1:0] idx,
        input logic [2:0]       bias,
        input logic [6:0]       con,
        input logic [6:0]       line
    );
        logic [7:0] b;
        case (idx)
            4'd0:    b = OP_BANK_EXT;
            4'd1:    b = OP_BIAS | {5'd0, bias};
            4'd2:    b = OP_LINE_HI | {7'd0, line[6]};
            4'd3:    b = OP_LINE_LO | {2'd0, line[5:0]};
            4'd4:    b = OP_BANK_STD;
            4'd5:    b = OP_DISP_NORM;
            4'd6:    b = OP_BANK_EXT;
            4'd7:    b = OP_CONTRAST | {1'b0, con};
            4'd8:    b = OP_BANK_STD;
            default: b = OP_BANK_STD;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/lcd_rst_timer.sv
module lcd_rst_timer
    import lcd_seq_pkg::*;
#(
    parameter int unsigned LOW_CYC  = 4,
    parameter int unsigned WAIT_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic lcd_rst_n,
    output logic fin
);
    localparam int unsigned MAX_CYC = (LOW_CYC > WAIT_CYC) ? LOW_CYC : WAIT_CYC;
    localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] LOW_END  = CNT_W'(LOW_CYC - 1);
    localparam logic [CNT_W-1:0] WAIT_END = CNT_W'(WAIT_CYC - 1);

    tm_phase_e        phase;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= TM_IDLE;
            cnt       <= '0;
            lcd_rst_n <= 1'b1;
            fin       <= 1'b0;
        end else begin
            fin <= 1'b0;
            case (phase)
                TM_IDLE: begin
                    if (go) begin
                        phase     <= TM_LOW;
                        cnt       <= '0;
                        lcd_rst_n <= 1'b0;
                    end
                end
                TM_LOW: begin
                    if (cnt == LOW_END) begin
                        phase     <= TM_WAIT;
                        cnt       <= '0;
                        lcd_rst_n <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                TM_WAIT: begin
                    if (cnt == WAIT_END) begin
                        phase <= TM_IDLE;
                        cnt   <= '0;
                        fin   <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: phase <= TM_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lcd_con_store.sv
module lcd_con_store #(
    parameter logic [6:0] CON_DEFAULT = 7'h28
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req,
    input  logic [6:0] val,
    input  logic       take,
    output logic       pend,
    output logic [6:0] con
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
            con  <= CON_DEFAULT;
        end else begin
            if (req) begin
                pend <= 1'b1;
                con  <= val;
            end else if (take) begin
                pend <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/lcd_byte_out.sv
module lcd_byte_out
    import lcd_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] load_byte,
    input  logic       ready,
    output logic [7:0] data,
    output logic       valid,
    output logic       accept
);
    cmd_slot_t slot;

    assign data   = slot.data;
    assign valid  = slot.valid;
    assign accept = slot.valid & ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot <= '{valid: 1'b0, data: 8'h00};
        end else if (load) begin
            slot <= '{valid: 1'b1, data: load_byte};
        end else if (accept) begin
            slot.valid <= 1'b0;
        end
    end
endmodule

// File: rtl/lcd_cmd_seq.sv
module lcd_cmd_seq
    import lcd_seq_pkg::*;
#(
    parameter int unsigned RST_LOW_CYC  = 4,
    parameter int unsigned RST_WAIT_CYC = 3,
    parameter logic [6:0]  CON_DEFAULT  = 7'h28,
    parameter logic [6:0]  START_LINE   = 7'd64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic [2:0] bias_i,
    input  logic       con_req_i,
    input  logic [6:0] con_val_i,
    output logic [7:0] byte_o,
    output logic       byte_valid_o,
    input  logic       byte_ready_i,
    output logic       lcd_rst_n_o,
    output logic       lcd_dc_o,
    output logic       done_o
);
    sq_state_e        state;
    logic [IDX_W-1:0] idx;
    logic [2:0]       bias_q;
    logic [6:0]       snap_q;
    logic             tm_go, tm_fin;
    logic             pend, take;
    logic [6:0]       con_cur;
    logic             load, accept;
    logic [7:0]       load_byte;
    logic [IDX_W-1:0] nidx;

    lcd_rst_timer #(.LOW_CYC(RST_LOW_CYC), .WAIT_CYC(RST_WAIT_CYC)) u_tmr (
        .clk(clk), .rst(rst), .go(tm_go), .lcd_rst_n(lcd_rst_n_o), .fin(tm_fin)
    );

    lcd_con_store #(.CON_DEFAULT(CON_DEFAULT)) u_con (
        .clk(clk), .rst(rst), .req(con_req_i), .val(con_val_i),
        .take(take), .pend(pend), .con(con_cur)
    );

    lcd_byte_out u_out (
        .clk(clk), .rst(rst), .load(load), .load_byte(load_byte),
        .ready(byte_ready_i), .data(byte_o), .valid(byte_valid_o), .accept(accept)
    );

    // Next-step decode: which list entry is loaded this cycle.
    always_comb begin
        tm_go     = 1'b0;
        take      = 1'b0;
        load      = 1'b0;
        nidx      = idx;
        load_byte = seq_byte(idx, bias_q, snap_q, START_LINE);
        case (state)
            SQ_IDLE: begin
                if (start_i) begin
                    tm_go = 1'b1;
                    take  = 1'b1;
                end else if (pend) begin
                    take      = 1'b1;
                    load      = 1'b1;
                    nidx      = IDX_CON;
                    load_byte = seq_byte(IDX_CON, bias_q, con_cur, START_LINE);
                end
            end
            SQ_RESET: begin
                if (tm_fin) begin
                    load      = 1'b1;
                    nidx      = '0;
                    load_byte = seq_byte('0, bias_q, snap_q, START_LINE);
                end
            end
            SQ_SEND: begin
                if (accept && idx != IDX_LAST) begin
                    load      = 1'b1;
                    nidx      = idx + 1'b1;
                    load_byte = seq_byte(idx + 1'b1, bias_q, snap_q, START_LINE);
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_IDLE;
            idx      <= '0;
            bias_q   <= '0;
            snap_q   <= CON_DEFAULT;
            lcd_dc_o <= 1'b1;
            done_o   <= 1'b0;
        end else begin
            done_o <= 1'b0;
            idx    <= nidx;
            case (state)
                SQ_IDLE: begin
                    if (start_i) begin
                        state    <= SQ_RESET;
                        bias_q   <= bias_i;
                        snap_q   <= con_cur;
                        lcd_dc_o <= 1'b0;
                    end else if (pend) begin
                        state    <= SQ_SEND;
                        snap_q   <= con_cur;
                        lcd_dc_o <= 1'b0;
                    end
                end
                SQ_RESET: begin
                    if (tm_fin) state <= SQ_SEND;
                end
                SQ_SEND: begin
                    if (accept && idx == IDX_LAST) begin
                        state    <= SQ_IDLE;
                        done_o   <= 1'b1;
                        lcd_dc_o <= 1'b1;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lcd_cmd_seq_chk.sv
module lcd_cmd_seq_chk #(
    parameter int unsigned RST_LOW_CYC = 4
) (
    input logic       clk,
    input logic       rst,
    input logic [7:0] byte_o,
    input logic       byte_valid_o,
    input logic       byte_ready_i,
    input logic       lcd_rst_n_o,
    input logic       lcd_dc_o,
    input logic       done_o
);
    logic [15:0] low_run;

    always_ff @(posedge clk) begin
        if (rst)               low_run <= '0;
        else if (!lcd_rst_n_o) low_run <= low_run + 1'b1;
        else                   low_run <= '0;
    end

    AST_BYTE_HOLD: assert property (@(posedge clk) disable iff (rst)
        byte_valid_o && !byte_ready_i |=> byte_valid_o && $stable(byte_o)); // R6

    AST_DC_CMD: assert property (@(posedge clk) disable iff (rst)
        byte_valid_o |-> !lcd_dc_o); // R7

    AST_RST_QUIET: assert property (@(posedge clk) disable iff (rst)
        !lcd_rst_n_o |-> !byte_valid_o); // R2

    AST_RST_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(lcd_rst_n_o) |-> low_run == 16'(RST_LOW_CYC)); // R2

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R10

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !byte_valid_o && lcd_dc_o); // R10
endmodule

bind lcd_cmd_seq lcd_cmd_seq_chk #(.RST_LOW_CYC(RST_LOW_CYC)) u_chk (
    .clk(clk), .rst(rst), .byte_o(byte_o), .byte_valid_o(byte_valid_o),
    .byte_ready_i(byte_ready_i), .lcd_rst_n_o(lcd_rst_n_o),
    .lcd_dc_o(lcd_dc_o), .done_o(done_o)
);

// File: tb/sim_lcd_cmd_seq.sv
module sim_lcd_cmd_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [2:0] bias_i = 3'd4;
    logic       con_req_i = 1'b0;
    logic [6:0] con_val_i = 7'd0;
    logic [7:0] byte_o;
    logic       byte_valid_o;
    logic       byte_ready_i = 1'b1;
    logic       lcd_rst_n_o, lcd_dc_o, done_o;

    always #4 clk = ~clk;

    lcd_cmd_seq u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .bias_i(bias_i),
        .con_req_i(con_req_i), .con_val_i(con_val_i), .byte_o(byte_o),
        .byte_valid_o(byte_valid_o), .byte_ready_i(byte_ready_i),
        .lcd_rst_n_o(lcd_rst_n_o), .lcd_dc_o(lcd_dc_o), .done_o(done_o)
    );

    int checks = 0, failures = 0;
    int done_cnt = 0, low_pulses = 0, low_run = 0, last_low = 0;
    int hold_err = 0, dc_err = 0, rst_tx_err = 0;
    bit rnd_ready = 1'b0;
    bit prev_hold = 1'b0;
    logic [7:0] prev_byte = 8'h00;
    logic [7:0] got[$];
    logic [7:0] exp_q[$];
    logic [6:0] model_con = 7'h28;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
        end
    endtask

    function automatic void push_bracket(input logic [6:0] v);
        exp_q.push_back(8'h21);
        exp_q.push_back(8'h80 | {1'b0, v});
        exp_q.push_back(8'h20);
    endfunction

    function automatic void push_init(input logic [2:0] b, input logic [6:0] v);
        exp_q.push_back(8'h21);
        exp_q.push_back(8'h10 | {5'd0, b});
        exp_q.push_back(8'h05);
        exp_q.push_back(8'h40);
        exp_q.push_back(8'h20);
        exp_q.push_back(8'h0C);
        push_bracket(v);
    endfunction

    // Monitor, sampled on the falling edge.
    always @(negedge clk) begin
        if (!rst) begin
            if (byte_valid_o && byte_ready_i) got.push_back(byte_o);
            if (done_o) done_cnt++;
            if (byte_valid_o && lcd_dc_o) dc_err++;
            if (byte_valid_o && !lcd_rst_n_o) rst_tx_err++;
            if (prev_hold && (!byte_valid_o || byte_o != prev_byte)) hold_err++;
            prev_hold = byte_valid_o && !byte_ready_i;
            prev_byte = byte_o;
            if (!lcd_rst_n_o) low_run++;
            else if (low_run != 0) begin
                last_low = low_run;
                low_run = 0;
                low_pulses++;
            end
        end
    end

    always @(posedge clk) begin
        #1;
        byte_ready_i = rnd_ready ? (($urandom % 3) != 0) : 1'b1;
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic do_start(input logic [2:0] b);
        start_i = 1'b1; bias_i = b;
        tick(1);
        start_i = 1'b0;
    endtask

    task automatic do_req(input logic [6:0] v);
        con_req_i = 1'b1; con_val_i = v;
        tick(1);
        con_req_i = 1'b0;
    endtask

    task automatic wait_done(input int target, input string tag);
        int t = 0;
        while (done_cnt < target && t < 3000) begin
            tick(1);
            t++;
        end
        chk(done_cnt >= target, {tag, " done reached"}, done_cnt, target);
        tick(3);
        chk(done_cnt == target, {tag, " done count"}, done_cnt, target);
    endtask

    task automatic compare(input string tag);
        chk(got.size() == exp_q.size(), {tag, " stream length"}, got.size(), exp_q.size());
        if (got.size() == exp_q.size())
            foreach (exp_q[i])
                chk(got[i] == exp_q[i], {tag, " stream byte"}, got[i], exp_q[i]);
        got.delete();
        exp_q.delete();
    endtask

    initial begin
        int wd = 0;
        while (wd < 150000) begin
            @(posedge clk);
            wd++;
        end
        failures++;
        checks++;
        $display("FAIL watchdog actual=0x%0h expected=0x0", wd);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int dn = 0;
        int lp;
        void'($urandom(32'd20240611));
        tick(4);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        chk(lcd_rst_n_o == 1'b1, "R1 rst_n", lcd_rst_n_o, 1);
        chk(byte_valid_o == 1'b0, "R1 valid", byte_valid_o, 0);
        chk(done_o == 1'b0, "R1 done", done_o, 0);
        chk(lcd_dc_o == 1'b1, "R1 dc", lcd_dc_o, 1);

        // R2 R3 R4: power-up with default bias and contrast
        do_start(3'd4);
        tick(1);
        chk(lcd_dc_o == 1'b0, "R7 dc low in sequence", lcd_dc_o, 0);
        push_init(3'd4, model_con);
        dn++; wait_done(dn, "R3 R4 init");
        compare("R3 R4 init");
        chk(last_low == 4, "R2 reset width", last_low, 4);
        chk(low_pulses == 1, "R2 reset pulses", low_pulses, 1);
        chk(lcd_dc_o == 1'b1, "R7 dc idle", lcd_dc_o, 1);

        // R5 contrast request while idle
        do_req(7'h45); model_con = 7'h45;
        push_bracket(7'h45);
        dn++; wait_done(dn, "R5 contrast");
        compare("R5 contrast");

        // R8 requests during init merge, last wins
        do_start(3'd2);
        tick(1);
        do_req(7'h11);
        do_req(7'h33);
        push_init(3'd2, model_con);
        model_con = 7'h33;
        push_bracket(7'h33);
        dn += 2; wait_done(dn, "R8 queued");
        compare("R8 queued");

        // R9 start during contrast sequence ignored
        lp = low_pulses;
        do_req(7'h0A); model_con = 7'h0A;
        tick(1);
        do_start(3'd7);
        push_bracket(7'h0A);
        dn++; wait_done(dn, "R9 start ignored");
        compare("R9 start ignored");
        chk(low_pulses == lp, "R9 no reset pulse", low_pulses, lp);

        // R11 start and request together
        start_i = 1'b1; bias_i = 3'd7; con_req_i = 1'b1; con_val_i = 7'h7F;
        tick(1);
        start_i = 1'b0; con_req_i = 1'b0;
        push_init(3'd7, model_con);
        model_con = 7'h7F;
        push_bracket(7'h7F);
        dn += 2; wait_done(dn, "R11 both");
        compare("R11 both");

        // R6 R10 random ops under random back-pressure
        rnd_ready = 1'b1;
        for (int k = 0; k < 24; k++) begin
            logic [2:0] b = 3'($urandom);
            logic [6:0] v = 7'($urandom);
            if (($urandom % 2) == 0) begin
                do_start(b);
                push_init(b, model_con);
            end else begin
                do_req(v);
                model_con = v;
                push_bracket(v);
            end
            dn++; wait_done(dn, "R6 R10 random");
            compare("R6 R10 random");
        end
        rnd_ready = 1'b0;
        chk(hold_err == 0, "R6 hold under back-pressure", hold_err, 0);
        chk(dc_err == 0, "R7 dc with bytes", dc_err, 0);
        chk(rst_tx_err == 0, "R2 no byte in reset", rst_tx_err, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule